// File: doc/BRIEF.md
# Power Mode State Controller

This block is the supervisor for the top-level power mode of a battery-powered chip. It decides whether the part is off, waiting in a low-current standby, fully active, or shutting down. Its inputs are digital flags that are already synchronous to the clock:

- a comparator flag for the battery under-voltage lockout level;
- a comparator flag for the battery-low alarm level;
- flags for a valid wall adapter and a valid USB supply;
- a debounced on/off button request;
- a completion handshake from the power-down sequencer.

A valid external supply keeps the part out of the off mode even when the battery is below lockout. A battery that shows up above the low-alarm level goes straight to active without a stop in standby.

The block raises a one-cycle start-power-up pulse when it enters active and a one-cycle start-power-down pulse when it begins shutting down. It then waits for the sequencer to report completion. A low-current enable is driven only in standby.

The block also holds a 5-bit, software-writable battery-low threshold code. It decodes this code to millivolts for the analog side.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While reset is asserted the outputs take these values: `mode` is 0 (off), `thr_rd_data` is 8'h0C, `thr_mv` is 2900, and `start_up`, `start_dn` and `stby_lp_en` are all 0. The mode encoding is 0 = off, 1 = standby, 2 = active, 3 = shutting down.
- R2: In off, with `bat_uvlo_ok`, `wall_ok` and `usb_ok` all low, the mode stays off, whatever `onoff_req` does.
- R3: In off, with any supply flag high and `bat_above_low` high, the next cycle is active. `start_up` is high for exactly that first active cycle.
- R4: In off, with any supply flag high and `bat_above_low` low, the next cycle is standby.
- R5: From standby, with some supply present, any of these moves the part to active on the next cycle, with a `start_up` pulse:
  - `onoff_req`;
  - a rising edge of `wall_ok`;
  - a rising edge of `usb_ok`.
  An external supply that is held steady does not wake the part.
- R6: In standby, with all three supply flags low, the next cycle is off. This takes priority over any wake event.
- R7: From active, `onoff_req` or the loss of all three supply flags moves the part to shutting down on the next cycle. `start_dn` is high for exactly that first cycle.
- R8: Shutting down is held until `pdn_done`. The next state is then standby if `bat_uvlo_ok` is high, otherwise off.
- R9: `stby_lp_en` is high exactly in the cycles where `mode` is standby.
- R10: A cycle with `thr_wr_en` high stores `thr_wr_data[4:0]`, which is visible on the next cycle. `thr_rd_data[7:5]` always reads 0. Without `thr_wr_en` the code is unchanged.
- R11: `thr_mv` equals 3500 - 50*code for codes 0 to 19 (so 3500 down to 2550). For codes 20 to 31 it equals 2500.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bat_uvlo_ok | input | 1 | Battery above the under-voltage lockout level |
| bat_above_low | input | 1 | Battery above the low-alarm level |
| wall_ok | input | 1 | Valid wall adapter supply present |
| usb_ok | input | 1 | Valid USB supply present |
| onoff_req | input | 1 | Debounced on/off button request |
| pdn_done | input | 1 | Power-down sequencer has finished |
| thr_wr_en | input | 1 | Threshold register write enable |
| thr_wr_data | input | 8 | Threshold register write data |
| thr_rd_data | output | 8 | Threshold register read data, bits 7:5 read as zero |
| thr_mv | output | 12 | Decoded battery-low threshold in millivolts |
| mode | output | 2 | Current mode: 0 off, 1 standby, 2 active, 3 shutting down |
| start_up | output | 1 | One-cycle pulse on entry to active |
| start_dn | output | 1 | One-cycle pulse on entry to shutting down |
| stby_lp_en | output | 1 | Low-current enable, standby only |

## Verification
The properties assume that every flag is already synchronous and holds steady for a whole cycle. They also assume that `pdn_done` is asserted only while the part is shutting down.

A wake event in standby is assumed to come with some supply present. The bench meets this because the `onoff_req` and supply edges it drives in standby always appear while the battery is above lockout or an external supply is valid.

The bench changes inputs only at the falling clock edge, one vector per cycle. It raises `pdn_done` only after a shutdown has begun.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
  localparam int THR_W    = 5;
  localparam int MV_W     = 12;
  localparam int MV_TOP   = 3500;
  localparam int MV_STEP  = 50;
  localparam int MV_FLOOR = 2500;
  localparam int CODE_SAT = 20;

  typedef enum logic [1:0] {
    M_OFF  = 2'd0,
    M_STBY = 2'd1,
    M_ACT  = 2'd2,
    M_DOWN = 2'd3
  } pmode_t;

  // threshold code to millivolts; saturates at the floor
  function automatic logic [MV_W-1:0] code_to_mv(input logic [THR_W-1:0] code);
    int v;
    if (int'(code) >= CODE_SAT) v = MV_FLOOR;
    else                        v = MV_TOP - MV_STEP * int'(code);
    return MV_W'(v);
  endfunction
endpackage

// File: rtl/pwr_edge_det.sv
module pwr_edge_det #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise
);
  logic [W-1:0] prev_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q[i] <= 1'b0;
      else        prev_q[i] <= lvl[i];
    end
    assign rise[i] = lvl[i] & ~prev_q[i];
  end
endmodule

// File: rtl/pwr_thr_reg.sv
module pwr_thr_reg
  import pwr_mode_pkg::*;
#(
  parameter int              DATA_W  = 8,
  parameter logic [THR_W-1:0] THR_RST = 5'h0C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic [MV_W-1:0]   mv
);
  localparam int RSV_W = DATA_W - THR_W;

  logic [THR_W-1:0] code_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     code_q <= THR_RST;
    else if (wr_en) code_q <= wr_data[THR_W-1:0];
  end

  assign rd_data = {{RSV_W{1'b0}}, code_q};
  assign mv      = code_to_mv(code_q);
endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
  import pwr_mode_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   supply_ok,
  input  logic   bat_uvlo_ok,
  input  logic   bat_above_low,
  input  logic   wake,
  input  logic   onoff_req,
  input  logic   pdn_done,
  output pmode_t state,
  output logic   start_up,
  output logic   start_dn
);
  pmode_t nxt;
  logic   up_n, dn_n;

  always_comb begin
    nxt  = state;
    up_n = 1'b0;
    dn_n = 1'b0;
    unique case (state)
      M_OFF: if (supply_ok) begin
        if (bat_above_low) begin nxt = M_ACT; up_n = 1'b1; end
        else                     nxt = M_STBY;
      end
      M_STBY: if (!supply_ok)  nxt = M_OFF;
              else if (wake) begin nxt = M_ACT; up_n = 1'b1; end
      M_ACT:  if (onoff_req || !supply_ok) begin nxt = M_DOWN; dn_n = 1'b1; end
      M_DOWN: if (pdn_done) nxt = bat_uvlo_ok ? M_STBY : M_OFF;
      default: nxt = M_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= M_OFF;
      start_up <= 1'b0;
      start_dn <= 1'b0;
    end else begin
      state    <= nxt;
      start_up <= up_n;
      start_dn <= dn_n;
    end
  end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
#(
  parameter int               DATA_W  = 8,
  parameter logic [THR_W-1:0] THR_RST = 5'h0C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bat_uvlo_ok,
  input  logic              bat_above_low,
  input  logic              wall_ok,
  input  logic              usb_ok,
  input  logic              onoff_req,
  input  logic              pdn_done,
  input  logic              thr_wr_en,
  input  logic [DATA_W-1:0] thr_wr_data,
  output logic [DATA_W-1:0] thr_rd_data,
  output logic [MV_W-1:0]   thr_mv,
  output logic [1:0]        mode,
  output logic              start_up,
  output logic              start_dn,
  output logic              stby_lp_en
);
  localparam int N_EXT = 2;

  // named internal events for the checker
  logic [N_EXT-1:0] ext_rise;
  logic             ins_evt;
  logic             wake_evt;
  logic             supply_ok;
  pmode_t           state;

  assign supply_ok = bat_uvlo_ok | wall_ok | usb_ok;

  pwr_edge_det #(.W(N_EXT)) u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .lvl  ({usb_ok, wall_ok}),
    .rise (ext_rise)
  );

  assign ins_evt  = |ext_rise;
  assign wake_evt = onoff_req | ins_evt;

  pwr_mode_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .supply_ok    (supply_ok),
    .bat_uvlo_ok  (bat_uvlo_ok),
    .bat_above_low(bat_above_low),
    .wake         (wake_evt),
    .onoff_req    (onoff_req),
    .pdn_done     (pdn_done),
    .state        (state),
    .start_up     (start_up),
    .start_dn     (start_dn)
  );

  pwr_thr_reg #(.DATA_W(DATA_W), .THR_RST(THR_RST)) u_thr (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (thr_wr_en),
    .wr_data(thr_wr_data),
    .rd_data(thr_rd_data),
    .mv     (thr_mv)
  );

  assign mode       = state;
  assign stby_lp_en = (state == M_STBY);
endmodule

// File: rtl/pwr_mode_chk.sv
module pwr_mode_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bat_uvlo_ok,
  input logic              wall_ok,
  input logic              usb_ok,
  input logic              onoff_req,
  input logic              pdn_done,
  input logic              wake_evt,
  input logic              thr_wr_en,
  input logic [DATA_W-1:0] thr_wr_data,
  input logic [DATA_W-1:0] thr_rd_data,
  input logic [11:0]       thr_mv,
  input logic [1:0]        mode,
  input logic              start_up,
  input logic              start_dn,
  input logic              stby_lp_en
);
  logic nosup;
  assign nosup = !bat_uvlo_ok && !wall_ok && !usb_ok;

  AST_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0 && nosup) |=> mode == 2'd0); // R2
  AST_UP_IN_ACT: assert property (@(posedge clk) disable iff (!rst_n)
    start_up |-> mode == 2'd2); // R3
  AST_UP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    start_up |=> !start_up); // R3
  AST_STBY_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1 && wake_evt && !nosup) |=> (mode == 2'd2 && start_up)); // R5
  AST_STBY_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1 && nosup) |=> mode == 2'd0); // R6
  AST_ACT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2 && onoff_req) |=> (mode == 2'd3 && start_dn)); // R7
  AST_DN_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    start_dn |=> !start_dn); // R7
  AST_DOWN_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd3 && !pdn_done) |=> mode == 2'd3); // R8
  AST_LP_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (stby_lp_en && onoff_req && !nosup) |=> !stby_lp_en); // R9
  AST_WR_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    thr_wr_en |=> thr_rd_data[4:0] == $past(thr_wr_data[4:0])); // R10
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !thr_wr_en |=> $stable(thr_rd_data)); // R10
  AST_MV_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    thr_mv >= 12'd2500 && thr_mv <= 12'd3500); // R11
endmodule

bind pwr_mode_ctrl pwr_mode_chk #(.DATA_W(DATA_W)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bat_uvlo_ok(bat_uvlo_ok),
  .wall_ok    (wall_ok),
  .usb_ok     (usb_ok),
  .onoff_req  (onoff_req),
  .pdn_done   (pdn_done),
  .wake_evt   (wake_evt),
  .thr_wr_en  (thr_wr_en),
  .thr_wr_data(thr_wr_data),
  .thr_rd_data(thr_rd_data),
  .thr_mv     (thr_mv),
  .mode       (mode),
  .start_up   (start_up),
  .start_dn   (start_dn),
  .stby_lp_en (stby_lp_en)
);

// File: tb/test_pwr_mode_ctrl.sv
module test_pwr_mode_ctrl;
  localparam int CLK_P = 10;
  localparam int NV    = 25;

  // {uvlo, low_ok, wall, usb, onoff, done, exp_mode[1:0], exp_up, exp_dn, exp_lp}
  localparam logic [10:0] VEC [NV] = '{
    11'b000000_00_000, // R2 nothing present
    11'b000010_00_000, // R2 button ignored
    11'b110000_10_100, // R3 straight to active
    11'b110000_10_000, // R3 pulse single
    11'b110010_11_010, // R7 button
    11'b110000_11_000, // R8 waiting
    11'b110001_01_001, // R8 done -> standby
    11'b110000_01_001, // R9
    11'b111000_10_100, // R5 wall plug
    11'b111010_11_010, // R7
    11'b111001_01_001, // R8
    11'b111000_01_001, // R5 steady wall no wake
    11'b110000_01_001, // wall removed
    11'b110100_10_100, // R5 usb plug
    11'b000000_11_010, // R7 supply loss
    11'b000001_00_000, // R8 done -> off
    11'b001000_01_001, // R4 external with low battery
    11'b001000_01_001, // R2 external holds out of off
    11'b000000_00_000, // R6
    11'b100000_01_001, // R4
    11'b100010_10_100, // R5 button wake
    11'b100000_10_000, // R3
    11'b100010_11_010, // R7
    11'b000001_00_000, // R8
    11'b110000_10_100  // R3
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic bat_uvlo_ok = 0, bat_above_low = 0, wall_ok = 0, usb_ok = 0;
  logic onoff_req = 0, pdn_done = 0, thr_wr_en = 0;
  logic [7:0]  thr_wr_data = 8'h00, thr_rd_data;
  logic [11:0] thr_mv;
  logic [1:0]  mode;
  logic start_up, start_dn, stby_lp_en;
  int errors = 0, checks = 0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  pwr_mode_ctrl i_pwr_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .bat_uvlo_ok(bat_uvlo_ok), .bat_above_low(bat_above_low),
    .wall_ok(wall_ok), .usb_ok(usb_ok), .onoff_req(onoff_req), .pdn_done(pdn_done),
    .thr_wr_en(thr_wr_en), .thr_wr_data(thr_wr_data), .thr_rd_data(thr_rd_data),
    .thr_mv(thr_mv), .mode(mode), .start_up(start_up), .start_dn(start_dn),
    .stby_lp_en(stby_lp_en)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_mv(input int code);
    if (code > 19) return 2500;
    return 2500 + (20 - code) * 50;
  endfunction

  initial begin
    #(CLK_P * 150000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 mode", mode, 0);
    chk("R1 rd", thr_rd_data, 8'h0C);
    chk("R1 mv", thr_mv, 2900);
    chk("R1 up", start_up, 0);
    chk("R1 dn", start_dn, 0);
    chk("R1 lp", stby_lp_en, 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      {bat_uvlo_ok, bat_above_low, wall_ok, usb_ok, onoff_req, pdn_done} = VEC[i][10:5];
      @(negedge clk);
      chk($sformatf("R2..vec%0d mode", i), mode, int'(VEC[i][4:3]));
      chk($sformatf("R3/R5 vec%0d up", i), start_up, int'(VEC[i][2]));
      chk($sformatf("R7 vec%0d dn", i), start_dn, int'(VEC[i][1]));
      chk($sformatf("R9 vec%0d lp", i), stby_lp_en, int'(VEC[i][0]));
    end
    onoff_req = 0; pdn_done = 0;

    // R10 R11: every code, with reserved bits set
    for (int c = 0; c < 32; c++) begin
      thr_wr_en = 1; thr_wr_data = 8'(c) | 8'hE0;
      @(negedge clk);
      chk($sformatf("R10 rd code%0d", c), thr_rd_data, c);
      chk($sformatf("R11 mv code%0d", c), thr_mv, exp_mv(c));
    end
    thr_wr_en = 1; thr_wr_data = 8'h07;
    @(negedge clk);
    thr_wr_en = 0; thr_wr_data = 8'h15;
    @(negedge clk);
    @(negedge clk);
    chk("R10 no write", thr_rd_data, 8'h07);
    chk("R11 hold mv", thr_mv, 3150);
    chk("R3 mode untouched by writes", mode, 2);

    // R1 reset in active mode
    rst_n = 0;
    @(negedge clk);
    chk("R1 mid mode", mode, 0);
    chk("R1 mid rd", thr_rd_data, 8'h0C);
    chk("R1 mid mv", thr_mv, 2900);
    rst_n = 1;
    @(negedge clk);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule